// File: doc/BRIEF.md
# SDRAM Masked-Write Command Sequencer

This block sits on the controller side of a double-data-rate SDRAM and carries out one whole masked write transaction per request. A request gives a bank, a row, a column, four data words and four per-word mask bits. Once accepted, the sequencer opens the row, issues the column write, sends the four data beats at two beats per clock together with their mask bits and a strobe output enable, and then closes the bank. Every cycle with no command in it carries a NOP.

The command spacing comes from nanosecond limits given as parameters. Each limit is turned into whole cycles by rounding up its ratio to the clock period. With a 7.5 ns clock, the activate-to-write gap of 20 ns becomes 3 cycles, the 40 ns minimum row-active time becomes 6, the 15 ns write recovery becomes 2 and the 20 ns precharge period becomes 3. A request flag picks whether the closing precharge acts on the addressed bank only or on all banks. A device-width parameter selects which address pins carry the column.

Top module: `sdram_wm_seq`

## Requirements
- R1: After reset, `req_ready` is high, `done` is low, the command is NOP ({ras_n,cas_n,we_n} = 3'b111), and `dq_oe` and `dqs_oe` are low.
- R2: In the cycle after a request is accepted (`req_valid` high while `req_ready` is high), the command is ACTIVE (3'b011), with `cmd_ba` set to the bank and `cmd_addr` set to the row.
- R3: WRITE (3'b100) appears ceil(tRCD/tCK) cycles after ACTIVE (3 by default), with the bank on `cmd_ba` and address bit 10 low so that auto precharge stays off.
- R4: The cycle after WRITE carries beat 0 on `dq_rise` and beat 1 on `dq_fall`. The next cycle carries beat 2 and beat 3. Beat i is `req_data[i*W +: W]`, and `dq_oe` is high in exactly these two cycles.
- R5: Mask bit i (`req_mask[i]`) goes out with beat i on `dm_rise`/`dm_fall`. A 1 blocks that beat from being written.
- R6: `dqs_oe` is high from the WRITE cycle (preamble) through the cycle after the last data cycle (postamble). That makes 4 cycles, and it is low otherwise.
- R7: PRECHARGE (3'b010) appears max(tRCD+3+tWR, tRAS) cycles after ACTIVE, in cycles rounded up (8 by default).
- R8: On PRECHARGE, `req_all_banks` = 1 drives address bit 10 high with `cmd_ba` = 0. A value of 0 drives bit 10 low with the request's bank on `cmd_ba`. All other address bits are 0.
- R9: `done` pulses for one cycle, and `req_ready` returns high, ceil(tRP/tCK) cycles after PRECHARGE (3 by default). Every cycle of the transaction other than ACTIVE, WRITE and PRECHARGE carries NOP.
- R10: While busy (`req_ready` low), changes on the request inputs and on `req_valid` have no effect on any output. The transaction finishes with the values captured at acceptance.
- R11: The column goes on address pins A0-A9 plus A11 for a 4-bit device, A0-A9 for an 8-bit device and A0-A8 for a 16-bit device. All other address pins are 0 on WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_bank | input | BA_W | Bank address |
| req_row | input | ROW_W | Row address |
| req_col | input | COL_W | Column address (width set by DEV_WIDTH) |
| req_all_banks | input | 1 | Precharge all banks at the end |
| req_data | input | 4*DEV_WIDTH | Four data beats, beat 0 lowest |
| req_mask | input | 4 | Per-beat mask, 1 blocks the beat |
| done | output | 1 | One-cycle pulse when the transaction ends |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BA_W | Bank address bus |
| cmd_addr | output | ROW_W | Address bus |
| dq_oe | output | 1 | Data beats valid this cycle |
| dqs_oe | output | 1 | Strobe output enable |
| dq_rise | output | DEV_WIDTH | Even beat of this cycle |
| dq_fall | output | DEV_WIDTH | Odd beat of this cycle |
| dm_rise | output | 1 | Mask for the even beat |
| dm_fall | output | 1 | Mask for the odd beat |

## Verification
Every result is due at a fixed cycle counted from acceptance. ACTIVE comes in the next cycle (k=0), WRITE at k=3, data at k=4 and k=5, strobe enable from k=3 to k=6, PRECHARGE at k=8, and `done` with `req_ready` at k=11. The bench works out these offsets from the nanosecond parameters by its own ceiling arithmetic. After the accepting edge it samples every output at the falling edge of each cycle k, so every command slot and every NOP slot is compared in the cycle where it is due. The busy-ignore scenario holds `req_valid` high with different request values up to k=10, and checks the whole transaction against the values captured at acceptance.

// File: rtl/sdram_wm_seq.sv
module sdram_wm_seq #(
  parameter int DEV_WIDTH = 8,
  parameter int BA_W      = 2,
  parameter int ROW_W     = 13,
  parameter int CLK_PS    = 7500,
  parameter int T_RCD_PS  = 20000,
  parameter int T_RAS_PS  = 40000,
  parameter int T_WR_PS   = 15000,
  parameter int T_RP_PS   = 20000,
  localparam int COL_W    = (DEV_WIDTH == 4) ? 11 : (DEV_WIDTH == 8) ? 10 : 9
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [BA_W-1:0]        req_bank,
  input  logic [ROW_W-1:0]       req_row,
  input  logic [COL_W-1:0]       req_col,
  input  logic                   req_all_banks,
  input  logic [4*DEV_WIDTH-1:0] req_data,
  input  logic [3:0]             req_mask,
  output logic                   done,
  output logic                   cmd_ras_n,
  output logic                   cmd_cas_n,
  output logic                   cmd_we_n,
  output logic [BA_W-1:0]        cmd_ba,
  output logic [ROW_W-1:0]       cmd_addr,
  output logic                   dq_oe,
  output logic                   dqs_oe,
  output logic [DEV_WIDTH-1:0]   dq_rise,
  output logic [DEV_WIDTH-1:0]   dq_fall,
  output logic                   dm_rise,
  output logic                   dm_fall
);
  localparam int RCD_CYC  = (T_RCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int RAS_CYC  = (T_RAS_PS + CLK_PS - 1) / CLK_PS;
  localparam int WR_CYC   = (T_WR_PS  + CLK_PS - 1) / CLK_PS;
  localparam int RP_CYC   = (T_RP_PS  + CLK_PS - 1) / CLK_PS;
  localparam int PRE_MIN  = RCD_CYC + 3 + WR_CYC;
  localparam int PRE_CYC  = (PRE_MIN > RAS_CYC) ? PRE_MIN : RAS_CYC;
  localparam int DONE_CYC = PRE_CYC + RP_CYC;
  localparam int CNT_W    = $clog2(DONE_CYC + 1);

  localparam logic [CNT_W-1:0] K_WR   = CNT_W'(RCD_CYC);
  localparam logic [CNT_W-1:0] K_D0   = CNT_W'(RCD_CYC + 1);
  localparam logic [CNT_W-1:0] K_D1   = CNT_W'(RCD_CYC + 2);
  localparam logic [CNT_W-1:0] K_POST = CNT_W'(RCD_CYC + 3);
  localparam logic [CNT_W-1:0] K_PRE  = CNT_W'(PRE_CYC);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(DONE_CYC - 1);

  logic                   busy;
  logic [CNT_W-1:0]       cyc;
  logic [BA_W-1:0]        ba_q;
  logic [ROW_W-1:0]       row_q;
  logic [COL_W-1:0]       col_q;
  logic                   all_q;
  logic [4*DEV_WIDTH-1:0] data_q;
  logic [3:0]             mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cyc    <= '0;
      done   <= 1'b0;
      ba_q   <= '0;
      row_q  <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      done <= busy && (cyc == K_LAST);
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          cyc    <= '0;
          ba_q   <= req_bank;
          row_q  <= req_row;
          col_q  <= req_col;
          all_q  <= req_all_banks;
          data_q <= req_data;
          mask_q <= req_mask;
        end
      end else if (cyc == K_LAST) begin
        busy <= 1'b0;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end

  logic is_act, is_wr, is_pre, in_d0, in_d1;
  assign is_act = busy && (cyc == '0);
  assign is_wr  = busy && (cyc == K_WR);
  assign is_pre = busy && (cyc == K_PRE);
  assign in_d0  = busy && (cyc == K_D0);
  assign in_d1  = busy && (cyc == K_D1);

  logic [ROW_W-1:0] col_addr;
  generate
    if (DEV_WIDTH == 4) begin : g_x4
      assign col_addr = {{(ROW_W-12){1'b0}}, col_q[10], 1'b0, col_q[9:0]};
    end else if (DEV_WIDTH == 8) begin : g_x8
      assign col_addr = {{(ROW_W-10){1'b0}}, col_q};
    end else begin : g_x16
      assign col_addr = {{(ROW_W-9){1'b0}}, col_q};
    end
  endgenerate

  logic [ROW_W-1:0] pre_addr;
  always_comb begin
    pre_addr     = '0;
    pre_addr[10] = all_q;
  end

  assign req_ready = !busy;
  assign cmd_ras_n = !(is_act || is_pre);
  assign cmd_cas_n = !is_wr;
  assign cmd_we_n  = !(is_wr || is_pre);
  assign cmd_ba    = (is_act || is_wr || (is_pre && !all_q)) ? ba_q : '0;
  assign cmd_addr  = is_act ? row_q : is_wr ? col_addr : is_pre ? pre_addr : '0;

  assign dq_oe   = in_d0 || in_d1;
  assign dqs_oe  = busy && (cyc >= K_WR) && (cyc <= K_POST);
  assign dq_rise = in_d0 ? data_q[0*DEV_WIDTH +: DEV_WIDTH] :
                   in_d1 ? data_q[2*DEV_WIDTH +: DEV_WIDTH] : '0;
  assign dq_fall = in_d0 ? data_q[1*DEV_WIDTH +: DEV_WIDTH] :
                   in_d1 ? data_q[3*DEV_WIDTH +: DEV_WIDTH] : '0;
  assign dm_rise = in_d0 ? mask_q[0] : in_d1 ? mask_q[2] : 1'b0;
  assign dm_fall = in_d0 ? mask_q[1] : in_d1 ? mask_q[3] : 1'b0;

  logic [7:0] since_act, since_data, since_pre;
  logic       bus_act, bus_wr, bus_pre;
  assign bus_act = !cmd_ras_n &&  cmd_cas_n &&  cmd_we_n;
  assign bus_wr  =  cmd_ras_n && !cmd_cas_n && !cmd_we_n;
  assign bus_pre = !cmd_ras_n &&  cmd_cas_n && !cmd_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act  <= 8'hFF;
      since_data <= 8'hFF;
      since_pre  <= 8'hFF;
    end else begin
      since_act  <= bus_act ? 8'd1 : (since_act  == 8'hFF ? since_act  : since_act  + 8'd1);
      since_data <= dq_oe   ? 8'd1 : (since_data == 8'hFF ? since_data : since_data + 8'd1);
      since_pre  <= bus_pre ? 8'd1 : (since_pre  == 8'hFF ? since_pre  : since_pre  + 8'd1);
    end
  end

  assert_act_to_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> (int'(since_act) >= RCD_CYC));
  assert_wr_no_autopre_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr |-> !cmd_addr[10]);
  assert_dq_inside_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe);
  assert_ras_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |-> (int'(since_act) >= RAS_CYC));
  assert_write_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pre |-> (int'(since_data) > WR_CYC));
  assert_precharge_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_act |-> (int'(since_pre) > RP_CYC));
  assert_done_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
  assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cmd_ras_n && cmd_cas_n && cmd_we_n && !dqs_oe));
endmodule

// File: tb/sdram_wm_seq_tb.sv
module sdram_wm_seq_tb;
  localparam int W = 8;
  localparam int CLK_PS = 7500;
  localparam int RCD = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int RAS = (40000 + CLK_PS - 1) / CLK_PS;
  localparam int WRC = (15000 + CLK_PS - 1) / CLK_PS;
  localparam int RP  = (20000 + CLK_PS - 1) / CLK_PS;
  localparam int KPRE  = (RCD + 3 + WRC > RAS) ? RCD + 3 + WRC : RAS;
  localparam int KDONE = KPRE + RP;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_all_banks = 0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic [4*W-1:0] req_data = '0;
  logic [3:0] req_mask = '0;
  logic req_ready, done, cmd_ras_n, cmd_cas_n, cmd_we_n, dq_oe, dqs_oe, dm_rise, dm_fall;
  logic [1:0] cmd_ba;
  logic [12:0] cmd_addr;
  logic [W-1:0] dq_rise, dq_fall;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  sdram_wm_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_all_banks(req_all_banks), .req_data(req_data), .req_mask(req_mask),
    .done(done), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
    .cmd_ba(cmd_ba), .cmd_addr(cmd_addr), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 done", done, 0);
    chk("R1 cmd", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b111);
    chk("R1 dq_oe", dq_oe, 0);
    chk("R1 dqs_oe", dqs_oe, 0);
  endtask

  task automatic run_txn(input logic [1:0] ba, input logic [12:0] row, input logic [9:0] col,
                         input logic [4*W-1:0] data, input logic [3:0] mask,
                         input logic allb, input bit hold_busy);
    chk("R9 ready before request", req_ready, 1);
    req_valid = 1; req_bank = ba; req_row = row; req_col = col;
    req_data = data; req_mask = mask; req_all_banks = allb;
    for (int k = 0; k <= KDONE; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R2 cmd", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b011);
        chk("R2 bank", cmd_ba, ba);
        chk("R2 row", cmd_addr, row);
      end else if (k == RCD) begin
        chk("R3 cmd", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b100);
        chk("R3 bank", cmd_ba, ba);
        chk("R3 R11 column map, A10 low", cmd_addr, {3'b000, col});
      end else if (k == KPRE) begin
        chk("R7 cmd", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b010);
        chk("R8 addr", cmd_addr, allb ? 13'h0400 : 13'h0000);
        chk("R8 bank", cmd_ba, allb ? 2'd0 : ba);
      end else begin
        chk("R9 nop", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b111);
      end
      chk("R4 dq_oe", dq_oe, (k == RCD + 1) || (k == RCD + 2));
      chk("R6 dqs_oe", dqs_oe, (k >= RCD) && (k <= RCD + 3));
      if (k == RCD + 1) begin
        chk("R4 beat0", dq_rise, data[0*W +: W]);
        chk("R4 beat1", dq_fall, data[1*W +: W]);
        chk("R5 mask0", dm_rise, mask[0]);
        chk("R5 mask1", dm_fall, mask[1]);
      end
      if (k == RCD + 2) begin
        chk("R4 beat2", dq_rise, data[2*W +: W]);
        chk("R4 beat3", dq_fall, data[3*W +: W]);
        chk("R5 mask2", dm_rise, mask[2]);
        chk("R5 mask3", dm_fall, mask[3]);
      end
      chk("R9 done", done, k == KDONE);
      chk("R9 R10 ready", req_ready, k == KDONE);
      if (k == 0) begin
        if (hold_busy) begin
          req_bank = ~ba; req_row = ~row; req_col = ~col;
          req_data = ~data; req_mask = ~mask; req_all_banks = ~allb;
        end else req_valid = 0;
      end
      if (hold_busy && k == KDONE - 1) req_valid = 0;
    end
  endtask

  task automatic test_single_bank();
    run_txn(2'd1, 13'h1ABC, 10'h055, 32'hD4C3B2A1, 4'b0000, 1'b0, 0);
  endtask

  task automatic test_all_banks_masked();
    run_txn(2'd3, 13'h0F0F, 10'h3FF, 32'h11223344, 4'b1010, 1'b1, 0);
  endtask

  task automatic test_busy_ignored();
    run_txn(2'd2, 13'h1555, 10'h2AA, 32'hCAFEF00D, 4'b0110, 1'b0, 1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R10 idle cmd after ignored traffic", {cmd_ras_n, cmd_cas_n, cmd_we_n}, 3'b111);
      chk("R10 ready stays", req_ready, 1);
    end
  endtask

  task automatic test_back_to_back();
    run_txn(2'd0, 13'h0001, 10'h200, 32'h80402010, 4'b0001, 1'b1, 0);
    run_txn(2'd1, 13'h1FFF, 10'h001, 32'h01020408, 4'b1111, 1'b0, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_single_bank();
    test_all_banks_masked();
    test_busy_ignored();
    test_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule